// File: doc/BRIEF.md
# Display RAM Write Address Controller

This block sits between a byte-stream decoder and the bit-addressed display RAM of a segment LCD driver. The drive runs at one of four multiplex rates, and several drivers can be cascaded on one shared stream. Command bytes load a write pointer or select which chip in the cascade should accept data. Each data byte then goes to the RAM at the pointer. After every data byte the pointer moves forward by a stride that depends on the drive mode.

Every chip in a cascade sees the same bytes. Only the chip whose strapped 3-bit subaddress equals its internal subaddress counter performs the write. All chips move their pointers by the same amount. When a pointer wraps past the top of the RAM, the subaddress counter on every chip steps on, so the stream passes to the next chip in the cascade.

The control is a two-state machine. The states are `PTR_UNSET` (the pointer is not trusted and data is discarded) and `PTR_ARMED` (data is written or skipped according to the subaddress match). The transitions are:

- reset to `PTR_UNSET`;
- a load-pointer command moves the machine from either state to `PTR_ARMED`;
- a transfer abort moves the machine from either state to `PTR_UNSET`;
- every other input leaves the state unchanged.

Top module: `dram_wr_ctrl`

## Requirements
- R1: After reset `ram_we` is 0, the pointer is unset and the subaddress counter is 0.
- R2: A command byte with bit 7 set is a load-pointer command. It loads the pointer with bits 6:0 and arms the machine. The next data byte appears one cycle later on `ram_addr`/`ram_data` at that address.
- R3: After every data byte accepted while armed, the pointer advances by a stride set by `drive_mode`: 0 (static) gives 8, 1 (1:2) gives 4, 2 (1:3) gives 3 and 3 (1:4) gives 2.
- R4: A command byte whose bits 7:3 are 01100 is a device-select command. It loads the subaddress counter with bits 2:0 and does not move the pointer.
- R5: A data byte is written only when the subaddress counter equals `hw_subaddr`. On a mismatch `ram_we` stays 0, but the pointer still advances.
- R6: The pointer wraps modulo 128. Every wrap increments the subaddress counter, which itself wraps from 7 to 0.
- R7: After `xfer_abort`, data bytes produce no write until the next load-pointer command.
- R8: `ram_we` pulses for exactly one cycle, in the cycle after an accepted data byte, and is 0 in every other cycle.
- R9: Command bytes that match neither encoding change neither the pointer nor the subaddress counter.
- R10: An abort leaves the subaddress counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Command or data byte |
| cmd_valid | input | 1 | `in_byte` is a command |
| data_valid | input | 1 | `in_byte` is display data |
| xfer_abort | input | 1 | Bus transfer ended early |
| drive_mode | input | 2 | Multiplex mode, which selects the pointer stride |
| hw_subaddr | input | 3 | Strapped device subaddress |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 7 | RAM bit address |
| ram_data | output | 8 | RAM write data |

## Verification
The assertions assume three things about the inputs:

- `cmd_valid` and `data_valid` are never high in the same cycle;
- `drive_mode` does not change inside a data burst;
- `hw_subaddr` is held still while bytes flow.

The bench keeps within these assumptions. It drives every input on the falling edge and raises at most one strobe per cycle. It changes the mode and the strap only between scenarios, and it reloads the pointer after each change.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;
    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_MUX2   = 2'd1,
        MODE_MUX3   = 2'd2,
        MODE_MUX4   = 2'd3
    } drive_mode_e;

    typedef enum logic {
        PTR_UNSET = 1'b0,
        PTR_ARMED = 1'b1
    } ptr_state_e;

    localparam int STEP_W = 4;

    function automatic logic [STEP_W-1:0] mode_step(input logic [1:0] mode);
        logic [STEP_W-1:0] s;
        unique case (drive_mode_e'(mode))
            MODE_STATIC: s = 4'd8;
            MODE_MUX2:   s = 4'd4;
            MODE_MUX3:   s = 4'd3;
            MODE_MUX4:   s = 4'd2;
            default:     s = 4'd2;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dram_ptr_unit.sv
module dram_ptr_unit
    import dram_wr_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [PTR_W-1:0]  load_val,
    input  logic              adv_en,
    input  logic [STEP_W-1:0] step,
    output logic [PTR_W-1:0]  ptr,
    output logic              wrap
);
    logic [PTR_W:0] sum;

    always_comb begin
        sum  = {1'b0, ptr} + {{(PTR_W+1-STEP_W){1'b0}}, step};
        wrap = adv_en && sum[PTR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= load_val;
        end else if (adv_en) begin
            ptr <= sum[PTR_W-1:0];
        end
    end

    // R3: an advance always moves the pointer
    a_r3_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en && !load_en |=> ptr != $past(ptr));
    // R2: a load puts the commanded value in place
    a_r2_ptr_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ptr == $past(load_val));
endmodule

// File: rtl/dram_sub_unit.sv
module dram_sub_unit #(
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_en,
    input  logic [SUB_W-1:0] sel_val,
    input  logic             inc_en,
    input  logic [SUB_W-1:0] hw_addr,
    output logic             match
);
    logic [SUB_W-1:0] sub_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
        end else if (sel_en) begin
            sub_cnt <= sel_val;
        end else if (inc_en) begin
            sub_cnt <= sub_cnt + 1'b1;
        end
    end

    assign match = (sub_cnt == hw_addr);

    // R10, R9: the counter holds without a select or a wrap
    a_r10_sub_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en && !inc_en |=> $stable(sub_cnt));
    // R6: a pointer wrap always moves the counter
    a_r6_sub_steps: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en && !sel_en |=> sub_cnt != $past(sub_cnt));
endmodule

// File: rtl/dram_wr_ctrl.sv
module dram_wr_ctrl
    import dram_wr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              cmd_valid,
    input  logic              data_valid,
    input  logic              xfer_abort,
    input  logic [1:0]        drive_mode,
    input  logic [SUB_W-1:0]  hw_subaddr,
    output logic              ram_we,
    output logic [DATA_W-2:0] ram_addr,
    output logic [DATA_W-1:0] ram_data
);
    localparam int PTR_W = DATA_W - 1;
    localparam int TAG_W = DATA_W - SUB_W;
    localparam logic [TAG_W-1:0] SEL_TAG = TAG_W'(5'b01100);

    ptr_state_e state_q, state_d;
    logic       is_load, is_sel, adv_en, wr_en, wrap, sub_match;
    logic [PTR_W-1:0] ptr;

    always_comb begin
        is_load = cmd_valid && !xfer_abort && in_byte[DATA_W-1];
        is_sel  = cmd_valid && !xfer_abort && (in_byte[DATA_W-1:SUB_W] == SEL_TAG);
        adv_en  = data_valid && !cmd_valid && !xfer_abort && (state_q == PTR_ARMED);
        wr_en   = adv_en && sub_match;
    end

    dram_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (is_load),
        .load_val (in_byte[PTR_W-1:0]),
        .adv_en   (adv_en),
        .step     (mode_step(drive_mode)),
        .ptr      (ptr),
        .wrap     (wrap)
    );

    dram_sub_unit #(.SUB_W(SUB_W)) u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_en  (is_sel),
        .sel_val (in_byte[SUB_W-1:0]),
        .inc_en  (wrap),
        .hw_addr (hw_subaddr),
        .match   (sub_match)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_UNSET: if (xfer_abort) state_d = PTR_UNSET;
                       else if (is_load) state_d = PTR_ARMED;
            PTR_ARMED: if (xfer_abort) state_d = PTR_UNSET;
            default:   state_d = PTR_UNSET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_UNSET;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= wr_en;
            if (adv_en) begin
                ram_addr <= ptr;
                ram_data <= in_byte;
            end
        end
    end

    // R7: an abort blocks the write in the following cycle
    a_r7_abort_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> !ram_we);
    // R8: a write enable follows a data strobe
    a_r8_we_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(data_valid) && !$past(cmd_valid));
    // R5: a write needs a subaddress match
    a_r5_we_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(sub_match));
    // R7: no write while the pointer is unset
    a_r7_unset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q) == PTR_UNSET |-> !ram_we);
endmodule

// File: tb/tb_dram_wr_ctrl.sv
module tb_dram_wr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       cmd_valid = 1'b0, data_valid = 1'b0, xfer_abort = 1'b0;
    logic [1:0] drive_mode = 2'd0;
    logic [2:0] hw_subaddr = 3'd0;
    logic       ram_we;
    logic [6:0] ram_addr;
    logic [7:0] ram_data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dram_wr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .cmd_valid(cmd_valid),
        .data_valid(data_valid), .xfer_abort(xfer_abort), .drive_mode(drive_mode),
        .hw_subaddr(hw_subaddr), .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    task automatic chk(string req, logic we, logic [6:0] addr, logic [7:0] data);
        checks++;
        if (ram_we !== we || (we && (ram_addr !== addr || ram_data !== data))) begin
            fails++;
            $display("FAIL %s: we=%0b addr=%0d data=%h expected we=%0b addr=%0d data=%h",
                     req, ram_we, ram_addr, ram_data, we, addr, data);
        end
    endtask

    task automatic cmd(logic [7:0] b);
        @(negedge clk); in_byte = b; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic dat(logic [7:0] b);
        @(negedge clk); in_byte = b; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic abort_pulse();
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", 1'b0, 7'd0, 8'h00);
        dat(8'h11); chk("R1", 1'b0, 7'd0, 8'h00);
    endtask

    task automatic t_basic();
        drive_mode = 2'd0; hw_subaddr = 3'd3;
        cmd(8'h63); cmd(8'h85);
        dat(8'hAA); chk("R2", 1'b1, 7'd5, 8'hAA);
        @(negedge clk); chk("R8", 1'b0, 7'd0, 8'h00);
        dat(8'h55); chk("R3", 1'b1, 7'd13, 8'h55);
    endtask

    task automatic t_modes();
        logic [6:0] stride [4] = '{7'd8, 7'd4, 7'd3, 7'd2};
        hw_subaddr = 3'd0; cmd(8'h60);
        for (int m = 0; m < 4; m++) begin
            drive_mode = 2'(m); cmd(8'h80 | 8'd10);
            dat(8'(m)); chk("R3", 1'b1, 7'd10, 8'(m));
            dat(8'(m + 16)); chk("R3", 1'b1, 7'd10 + stride[m], 8'(m + 16));
        end
    endtask

    task automatic t_mismatch();
        drive_mode = 2'd0; hw_subaddr = 3'd3;
        cmd(8'h62); cmd(8'h80);
        dat(8'h01); chk("R5", 1'b0, 7'd0, 8'h00);
        cmd(8'h63);
        dat(8'h02); chk("R5", 1'b1, 7'd8, 8'h02);
        chk("R4", 1'b1, 7'd8, 8'h02);
    endtask

    task automatic t_overflow();
        drive_mode = 2'd2; hw_subaddr = 3'd1;
        cmd(8'h60); cmd(8'h80 | 8'd126);
        dat(8'h33); chk("R6", 1'b0, 7'd0, 8'h00);
        dat(8'h44); chk("R6", 1'b1, 7'd1, 8'h44);
        drive_mode = 2'd0; hw_subaddr = 3'd0;
        cmd(8'h67); cmd(8'h80 | 8'd120);
        dat(8'h77); chk("R6", 1'b0, 7'd0, 8'h00);
        dat(8'h88); chk("R6", 1'b1, 7'd0, 8'h88);
    endtask

    task automatic t_abort();
        drive_mode = 2'd3; hw_subaddr = 3'd5;
        cmd(8'h65); cmd(8'h80 | 8'd20);
        abort_pulse();
        dat(8'h99); chk("R7", 1'b0, 7'd0, 8'h00);
        cmd(8'h80 | 8'd30);
        dat(8'h9A); chk("R7", 1'b1, 7'd30, 8'h9A);
        abort_pulse();
        cmd(8'h80);
        dat(8'h9B); chk("R10", 1'b1, 7'd0, 8'h9B);
    endtask

    task automatic t_other_cmd();
        drive_mode = 2'd0; hw_subaddr = 3'd2;
        cmd(8'h62); cmd(8'h80 | 8'd40);
        cmd(8'h10); cmd(8'h6F);
        dat(8'hC3); chk("R9", 1'b1, 7'd40, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_modes();
        t_mismatch();
        t_overflow();
        t_abort();
        t_other_cmd();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule